// File: doc/BRIEF.md
# Converter Result Register with Atomic Byte Access

This block sits between an analog converter and an 8-bit register bus. The converter hands it a 10-bit result together with a one-cycle done strobe. The block keeps the result and presents it as two read-only bytes, a low byte and a high byte. A control input sets whether the 10-bit value is packed toward the bottom or toward the top of the 16-bit pair. Alignment is applied when the bytes are read, so the stored value never changes when the control input changes.

A reader that needs the full result reads the low byte first and the high byte second. The low-byte read freezes the visible value, and the high-byte read releases it, so the two bytes always come from the same sample. A result that arrives while the pair is frozen waits in a one-deep pending slot. When the freeze ends, the pending result moves into the visible register, and a newer arrival replaces an older pending one. A high-byte read on its own never freezes anything, so a reader using top alignment can poll the high byte alone for an 8-bit result. For signed results, the sign bit stays in the most significant result position in both alignments.

Top module: `conv_result_reg`

## Requirements
- R1: With `align_left` low, address 0 reads result bits 7:0, and address 1 reads result bits 9:8 in bits 1:0 with bits 7:2 zero.
- R2: With `align_left` high, address 1 reads result bits 9:2, and address 0 reads result bits 1:0 in bits 7:6 with bits 5:0 zero.
- R3: After a synchronous reset both bytes read zero and the pair is not frozen.
- R4: A read of address 0 freezes the visible result. A done strobe in that cycle, or in any later cycle before a read of address 1, does not change what either byte returns.
- R5: A read of address 1 while the pair is not frozen does not freeze it, and a later done strobe updates the bytes.
- R6: Result bit 9, the sign of a two's complement result, reads at address 1 bit 1 when right aligned and at address 1 bit 7 when left aligned.
- R7: A result that arrives while the pair is frozen is held. It becomes visible on the cycle after the releasing address-1 read. If several arrive, the newest wins, and that includes one that arrives in the releasing cycle.
- R8: Changing `align_left` changes only the byte mapping on later reads. The stored 10-bit value is left as it is, even while the pair is frozen.
- R9: A cycle with `bus_wr` high is not a read. It returns zero, does not freeze the pair, and changes no stored value, whatever the address.
- R10: A done strobe while the pair is not frozen and no address-0 read is in progress makes `conv_data` visible from the next cycle.
- R11: Reads of any address other than 0 and 1 return zero and do not freeze the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_data | input | 10 | Result from the converter |
| conv_done | input | 1 | One-cycle strobe: conv_data is a new result |
| align_left | input | 1 | 1 = left aligned, 0 = right aligned |
| bus_addr | input | 2 | Byte address: 0 low, 1 high |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe; writes are ignored |
| bus_rdata | output | 8 | Read data, valid combinationally in the read cycle |

## Verification
Some rules are checked by assertions on every cycle:
- the visible value holds still while the pair is frozen;
- an address-0 read sets the freeze, and only an address-0 read can set it;
- a release moves the pending value into the visible register;
- an unfrozen strobe is captured;
- the sign bit lands at the stated high-byte position;
- write cycles never turn into reads.

Other behaviour shows only in the bench's scenarios:
- the full byte mapping over every 10-bit value in both alignments;
- newest-wins among several pending arrivals, including a strobe in the releasing cycle;
- an alignment change made while the pair is frozen;
- proof at the ports that writes and reads of unused addresses leave the register unchanged.

// File: rtl/cres_pkg.sv
package cres_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } byte_sel_e;

    typedef struct packed {
        logic      lo_rd;
        logic      hi_rd;
        byte_sel_e sel;
    } bus_req_t;

    // Place a result of res_w bits inside the 16-bit pair.
    function automatic logic [WORD_W-1:0] pack_word(logic [WORD_W-1:0] res_ext,
                                                    int unsigned res_w,
                                                    logic left);
        logic [WORD_W-1:0] w;
        w = res_ext;
        if (left) w = w << (WORD_W - res_w);
        return w;
    endfunction
endpackage

// File: rtl/cres_decode.sv
module cres_decode
    import cres_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int LO_ADDR = 0,
    parameter int HI_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output bus_req_t          req
);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);

    logic rd_ok;

    always_comb begin
        rd_ok     = rd && !wr;   // a write cycle is never a read
        req.lo_rd = rd_ok && (addr == LO_A);
        req.hi_rd = rd_ok && (addr == HI_A);
        if (req.hi_rd)      req.sel = SEL_HI;
        else if (req.lo_rd) req.sel = SEL_LO;
        else                req.sel = SEL_NONE;
    end

    p_onehot_strobes_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req.lo_rd, req.hi_rd}));
    p_write_no_read_r9: assert property (@(posedge clk) disable iff (rst)
        wr |-> (!req.lo_rd && !req.hi_rd && req.sel == SEL_NONE));
endmodule

// File: rtl/cres_hold.sv
module cres_hold #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cv_done,
    input  logic [RES_W-1:0] cv_data,
    input  logic             lo_rd,
    input  logic             hi_rd,
    output logic [RES_W-1:0] vis,
    output logic             locked
);
    logic [RES_W-1:0] pend;
    logic             pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            vis    <= '0;
            pend   <= '0;
            pend_v <= 1'b0;
            locked <= 1'b0;
        end else if (locked) begin
            if (hi_rd) begin
                locked <= 1'b0;
                pend_v <= 1'b0;
                if (cv_done)     vis <= cv_data;
                else if (pend_v) vis <= pend;
            end else if (cv_done) begin
                pend   <= cv_data;
                pend_v <= 1'b1;
            end
        end else if (lo_rd) begin
            locked <= 1'b1;
            if (cv_done) begin
                pend   <= cv_data;
                pend_v <= 1'b1;
            end
        end else if (cv_done) begin
            vis <= cv_data;
        end
    end

    p_reset_clear_r3: assert property (@(posedge clk)
        rst |=> (vis == '0 && !locked && !pend_v));
    p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        (locked && !hi_rd) |=> $stable(vis));
    p_lock_on_low_r4: assert property (@(posedge clk) disable iff (rst)
        (!locked && lo_rd) |=> locked);
    p_no_lock_else_r5: assert property (@(posedge clk) disable iff (rst)
        (!locked && !lo_rd) |=> !locked);
    p_release_pending_r7: assert property (@(posedge clk) disable iff (rst)
        (locked && hi_rd && pend_v && !cv_done) |=> (vis == $past(pend) && !locked));
    p_release_newest_r7: assert property (@(posedge clk) disable iff (rst)
        (locked && hi_rd && cv_done) |=> (vis == $past(cv_data)));
    p_capture_r10: assert property (@(posedge clk) disable iff (rst)
        (!locked && !lo_rd && cv_done) |=> (vis == $past(cv_data)));
endmodule

// File: rtl/cres_align.sv
module cres_align
    import cres_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RES_W-1:0] vis,
    input  logic             left,
    input  byte_sel_e        sel,
    output logic [BYTE_W-1:0] rdata
);
    localparam int SIGN_R = RES_W - 1 - BYTE_W;  // sign position in high byte, right aligned
    localparam int SIGN_L = BYTE_W - 1;

    logic [WORD_W-1:0] word;

    always_comb begin
        word = pack_word(WORD_W'(vis), RES_W, left);
        case (sel)
            SEL_HI:  rdata = word[WORD_W-1:BYTE_W];
            SEL_LO:  rdata = word[BYTE_W-1:0];
            default: rdata = '0;
        endcase
    end

    p_sign_pos_r6: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_HI) |-> (rdata[left ? SIGN_L : SIGN_R] == vis[RES_W-1]));
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (rdata == '0));
endmodule

// File: rtl/conv_result_reg.sv
module conv_result_reg
    import cres_pkg::*;
#(
    parameter int RES_W   = 10,
    parameter int ADDR_W  = 2,
    parameter int LO_ADDR = 0,
    parameter int HI_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              conv_done,
    input  logic              align_left,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [BYTE_W-1:0] bus_rdata
);
    bus_req_t         req;
    logic [RES_W-1:0] vis;
    logic             locked;

    initial begin
        if (RES_W <= BYTE_W || RES_W > WORD_W)
            $error("RES_W must lie between BYTE_W+1 and WORD_W");
    end

    cres_decode #(
        .ADDR_W (ADDR_W),
        .LO_ADDR(LO_ADDR),
        .HI_ADDR(HI_ADDR)
    ) u_decode (
        .clk (clk),
        .rst (rst),
        .addr(bus_addr),
        .rd  (bus_rd),
        .wr  (bus_wr),
        .req (req)
    );

    cres_hold #(
        .RES_W(RES_W)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .cv_done(conv_done),
        .cv_data(conv_data),
        .lo_rd  (req.lo_rd),
        .hi_rd  (req.hi_rd),
        .vis    (vis),
        .locked (locked)
    );

    cres_align #(
        .RES_W(RES_W)
    ) u_align (
        .clk  (clk),
        .rst  (rst),
        .vis  (vis),
        .left (align_left),
        .sel  (req.sel),
        .rdata(bus_rdata)
    );

    p_wr_keeps_lock_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !locked) |=> !locked);
endmodule

// File: tb/sim_conv_result_reg.sv
`timescale 1ns/1ps
module sim_conv_result_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] conv_data = '0;
    logic       conv_done = 1'b0;
    logic       align_left = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] rb;

    always #2.5 clk = ~clk;

    conv_result_reg u0 (
        .clk(clk), .rst(rst), .conv_data(conv_data), .conv_done(conv_done),
        .align_left(align_left), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, sample the read data 1 ns later.
    task automatic cyc(input logic done, input logic [9:0] data, input logic rd,
                       input logic wr, input logic [1:0] addr, input logic left,
                       output logic [7:0] r);
        @(negedge clk);
        conv_done  = done;
        conv_data  = data;
        bus_rd     = rd;
        bus_wr     = wr;
        bus_addr   = addr;
        align_left = left;
        #1 r = bus_rdata;
    endtask

    function automatic logic [7:0] exp_lo(input logic [9:0] v, input logic left);
        return left ? 8'((v & 10'h3) << 6) : 8'(v & 10'hFF);
    endfunction
    function automatic logic [7:0] exp_hi(input logic [9:0] v, input logic left);
        return left ? 8'(v >> 2) : 8'(v >> 8);
    endfunction

    task automatic push(input logic [9:0] v, input logic left);
        logic [7:0] d;
        cyc(1'b1, v, 1'b0, 1'b0, 2'd0, left, d);
    endtask
    task automatic rd_byte(input logic [1:0] a, input logic left, output logic [7:0] r);
        cyc(1'b0, '0, 1'b1, 1'b0, a, left, r);
    endtask

    initial begin
        #(5.0 * 190000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R3 reset state
        rd_byte(2'd0, 1'b0, rb); chk("R3 low after reset", rb, 8'h00);
        rd_byte(2'd1, 1'b0, rb); chk("R3 high after reset", rb, 8'h00);

        // R1 R2 R6 R10: every value, both alignments
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 1024; v++) begin
                push(10'(v), m[0]);
                rd_byte(2'd0, m[0], rb);
                chk(m ? "R2 low byte" : "R1 low byte", rb, exp_lo(10'(v), m[0]));
                rd_byte(2'd1, m[0], rb);
                chk(m ? "R2 high byte" : "R1 high byte", rb, exp_hi(10'(v), m[0]));
                if (v >= 512) chk("R6 sign bit", 8'(rb[m ? 7 : 1]), 8'h01);
                else          chk("R6 sign bit", 8'(rb[m ? 7 : 1]), 8'h00);
            end
        end

        // R4: done in the low-read cycle and after it are both held back
        push(10'h155, 1'b0);
        cyc(1'b1, 10'h2AA, 1'b1, 1'b0, 2'd0, 1'b0, rb); chk("R4 low read with done", rb, 8'h55);
        push(10'h3C3, 1'b0);
        rd_byte(2'd0, 1'b0, rb); chk("R4 low frozen", rb, 8'h55);
        rd_byte(2'd1, 1'b0, rb); chk("R4 high frozen", rb, 8'h01);
        // R7: newest pending becomes visible after release
        rd_byte(2'd0, 1'b0, rb); chk("R7 newest pending low", rb, 8'hC3);
        rd_byte(2'd1, 1'b0, rb); chk("R7 newest pending high", rb, 8'h03);

        // R7: arrival in the releasing cycle wins over an older pending one
        push(10'h011, 1'b0);
        rd_byte(2'd0, 1'b0, rb);
        push(10'h022, 1'b0);
        cyc(1'b1, 10'h233, 1'b1, 1'b0, 2'd1, 1'b0, rb); chk("R7 release returns frozen", rb, 8'h00);
        rd_byte(2'd0, 1'b0, rb); chk("R7 release-cycle arrival low", rb, 8'h33);
        rd_byte(2'd1, 1'b0, rb); chk("R7 release-cycle arrival high", rb, 8'h02);

        // R5: high-only reads never freeze
        push(10'h1F0, 1'b1);
        rd_byte(2'd1, 1'b1, rb); chk("R5 high poll", rb, 8'h7C);
        push(10'h30F, 1'b1);
        rd_byte(2'd1, 1'b1, rb); chk("R5 high poll updates", rb, 8'hC3);

        // R8: alignment change while frozen keeps the stored value
        push(10'h2D7, 1'b0);
        rd_byte(2'd0, 1'b0, rb); chk("R8 low right", rb, 8'hD7);
        push(10'h001, 1'b1);
        rd_byte(2'd0, 1'b1, rb); chk("R8 low left same value", rb, 8'hC0);
        rd_byte(2'd1, 1'b1, rb); chk("R8 high left same value", rb, 8'hB5);
        rd_byte(2'd0, 1'b0, rb); chk("R8 back to right after release", rb, 8'h01);
        rd_byte(2'd1, 1'b0, rb);

        // R9: writes, alone or with a read strobe, do nothing
        push(10'h0AB, 1'b0);
        cyc(1'b0, '0, 1'b0, 1'b1, 2'd0, 1'b0, rb);
        cyc(1'b0, '0, 1'b1, 1'b1, 2'd0, 1'b0, rb); chk("R9 write cycle reads zero", rb, 8'h00);
        cyc(1'b0, '0, 1'b1, 1'b1, 2'd1, 1'b0, rb);
        rd_byte(2'd1, 1'b0, rb); chk("R9 value unchanged", rb, 8'h00);
        rd_byte(2'd1, 1'b1, rb); chk("R9 value unchanged left", rb, 8'h2A);
        push(10'h3FE, 1'b0);
        rd_byte(2'd0, 1'b0, rb); chk("R9 no freeze from write", rb, 8'hFE);
        rd_byte(2'd1, 1'b0, rb);

        // R11: unused addresses read zero and do not freeze
        rd_byte(2'd2, 1'b0, rb); chk("R11 addr 2 zero", rb, 8'h00);
        rd_byte(2'd3, 1'b0, rb); chk("R11 addr 3 zero", rb, 8'h00);
        push(10'h123, 1'b0);
        rd_byte(2'd0, 1'b0, rb); chk("R11 no freeze from unused", rb, 8'h23);
        rd_byte(2'd1, 1'b0, rb); chk("R11 high", rb, 8'h01);

        // R3: reset mid-freeze clears everything
        rd_byte(2'd0, 1'b0, rb);
        @(negedge clk); rst = 1'b1; bus_rd = 1'b0;
        @(negedge clk); rst = 1'b0;
        push(10'h044, 1'b0);
        rd_byte(2'd0, 1'b0, rb); chk("R3 reset releases freeze", rb, 8'h44);
        rd_byte(2'd1, 1'b0, rb);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule